// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This block holds the condition state of a 32-bit processor that uses 16-bit instructions, and it decides conditional branches from that state. A compare strobe takes two register operands and stores five relation flags: equal, signed less, signed greater, unsigned less and unsigned greater. A later branch instruction names one of ten conditions over those flags and carries a signed halfword displacement. The block returns whether the branch is taken, the address of the next instruction, and a flag for condition encodings that do not exist.

The block does not fetch instructions and holds neither the register file nor the program counter. Each cycle it sees only the compare operands with their strobe, the branch word with its valid bit, and the current PC. Branch results are combinational and come from the flags as they were stored before the current cycle. A compare and a branch in the same cycle therefore do not interact: the branch uses the older flags.

Top module: `cmp_branch_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all five flags to zero.
- R2: When `cmp_valid` is high at a rising edge, `cc_flags` takes on the new relation flags after that edge. Bit 0 is set when the operands are equal. Bit 1 is set when A is below B as signed values and bit 2 when A is above B as signed values. Bit 3 is set when A is below B as unsigned values and bit 4 when A is above B as unsigned values. Every other flag bit is zero.
- R3: When `cmp_valid` is low the flags keep their value. A branch evaluated in the same cycle as a compare strobe uses the flags stored before that strobe.
- R4: A branch word has bits 15 and 14 both set, the condition in bits 13:10 and the displacement in bits 9:0. When `br_valid` is low, or the word is not a branch word, `br_taken` and `br_illegal` are both low and `next_pc` is PC+2.
- R5: Conditions 0 to 5 take the branch when, in order, EQ is set, EQ is clear, LT is set, GT is set, LTU is set, or GTU is set.
- R6: Conditions 6 to 9 take the branch when, in order, GT or EQ is set, LT or EQ is set, GTU or EQ is set, or LTU or EQ is set.
- R7: Conditions 10 to 15 raise `br_illegal`, never take the branch, and hold `next_pc` equal to PC.
- R8: A taken branch gives `next_pc` = PC + 2 × (bits 9:0 sign-extended from 10 bits), modulo 2^32.
- R9: A legal branch that is not taken gives `next_pc` = PC + 2, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare strobe; stores new flags at the edge |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch word present this cycle |
| br_insn | input | 16 | Instruction word to decode as a branch |
| pc | input | 32 | Address of the current instruction |
| br_taken | output | 1 | Branch condition holds |
| br_illegal | output | 1 | Condition encoding 10 to 15 was seen |
| next_pc | output | 32 | Address of the next instruction |
| cc_flags | output | 5 | Stored flags {GTU, LTU, GT, LT, EQ} |

## Verification
Flags are due one rising edge after the compare strobe. All branch outputs are combinational on the current branch word, the PC and the flags already stored, so they are due in the same cycle. The bench drives each stimulus on the falling edge and samples every output 2 ns later, before the next rising edge. It updates its reference flags only at that rising edge, so a branch issued next to a compare is always checked against the flags from before the compare.

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int XLEN = 32,
  parameter int IW   = 16,
  parameter int OFFW = 10,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_valid,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  input  logic            br_valid,
  input  logic [IW-1:0]   br_insn,
  input  logic [XLEN-1:0] pc,
  output logic            br_taken,
  output logic            br_illegal,
  output logic [XLEN-1:0] next_pc,
  output logic [4:0]      cc_flags
);

  localparam logic [XLEN-1:0] STEP = XLEN'(2);
  localparam logic [CW-1:0]   LAST_LEGAL = CW'(9);

  logic          f_eq, f_lt, f_gt, f_ltu, f_gtu;
  logic [CW-1:0] cond;
  logic          is_br, hit, bad;
  logic [XLEN-1:0] disp;

  always_ff @(posedge clk) begin
    if (rst) begin
      {f_gtu, f_ltu, f_gt, f_lt, f_eq} <= '0;
    end else if (cmp_valid) begin
      f_eq  <= (cmp_a == cmp_b);
      f_lt  <= ($signed(cmp_a) < $signed(cmp_b));
      f_gt  <= ($signed(cmp_a) > $signed(cmp_b));
      f_ltu <= (cmp_a < cmp_b);
      f_gtu <= (cmp_a > cmp_b);
    end
  end

  assign cc_flags = {f_gtu, f_ltu, f_gt, f_lt, f_eq};

  assign cond  = br_insn[OFFW+CW-1:OFFW];
  assign is_br = br_valid & (&br_insn[IW-1:OFFW+CW]);
  assign bad   = (cond > LAST_LEGAL);

  always_comb begin
    case (cond)
      4'd0:    hit = f_eq;
      4'd1:    hit = ~f_eq;
      4'd2:    hit = f_lt;
      4'd3:    hit = f_gt;
      4'd4:    hit = f_ltu;
      4'd5:    hit = f_gtu;
      4'd6:    hit = f_gt  | f_eq;
      4'd7:    hit = f_lt  | f_eq;
      4'd8:    hit = f_gtu | f_eq;
      4'd9:    hit = f_ltu | f_eq;
      default: hit = 1'b0;
    endcase
  end

  assign disp = {{(XLEN-OFFW-1){br_insn[OFFW-1]}}, br_insn[OFFW-1:0], 1'b0};

  assign br_illegal = is_br & bad;
  assign br_taken   = is_br & ~bad & hit;
  assign next_pc    = br_illegal ? pc : (pc + (br_taken ? disp : STEP));

endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk #(
  parameter int XLEN = 32,
  parameter int IW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cmp_valid,
  input logic [XLEN-1:0] cmp_a,
  input logic [XLEN-1:0] cmp_b,
  input logic            br_valid,
  input logic [IW-1:0]   br_insn,
  input logic [XLEN-1:0] pc,
  input logic            br_taken,
  input logic            br_illegal,
  input logic [XLEN-1:0] next_pc,
  input logic [4:0]      cc_flags
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> cc_flags == 5'b0); // R1
  AST_EQ_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    cmp_valid && (cmp_a == cmp_b) |=> cc_flags == 5'b00001); // R2
  AST_UNSIGNED_BELOW: assert property (@(posedge clk) disable iff (rst)
    cmp_valid && (cmp_a < cmp_b) |=> cc_flags[3] && !cc_flags[4] && !cc_flags[0]); // R2
  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cc_flags[2:0]) && $onehot0({cc_flags[4:3], cc_flags[0]})); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(cc_flags)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !br_valid |-> !br_taken && !br_illegal && next_pc == pc + 32'd2); // R4
  AST_EQ_BRANCH: assert property (@(posedge clk) disable iff (rst)
    br_valid && br_insn[15:10] == 6'b110000 |-> br_taken == cc_flags[0]); // R5
  AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    br_valid && (&br_insn[15:14]) && br_insn[13:10] > 4'd9 |-> br_illegal); // R7
  AST_ILLEGAL_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    br_illegal |-> !br_taken && next_pc == pc); // R7
  AST_FALLTHROUGH_STEP: assert property (@(posedge clk) disable iff (rst)
    br_valid && !br_taken && !br_illegal |-> next_pc == pc + 32'd2); // R9

endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(.XLEN(XLEN), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .br_valid(br_valid), .br_insn(br_insn), .pc(pc), .br_taken(br_taken),
  .br_illegal(br_illegal), .next_pc(next_pc), .cc_flags(cc_flags)
);

// File: tb/cmp_branch_unit_bench.sv
`timescale 1ns/1ps
module cmp_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [15:0] br_insn = '0;
  logic [31:0] pc = '0;
  logic        br_taken, br_illegal;
  logic [31:0] next_pc;
  logic [4:0]  cc_flags;

  int checks = 0;
  int fails  = 0;
  bit m_eq, m_lt, m_gt, m_ltu, m_gtu;

  always #4 clk = ~clk;

  cmp_branch_unit u_cmp_branch_unit (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_insn(br_insn), .pc(pc), .br_taken(br_taken),
    .br_illegal(br_illegal), .next_pc(next_pc), .cc_flags(cc_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string ftag, input bit r, input bit cv, input logic [31:0] a,
                      input logic [31:0] b, input bit bv, input logic [15:0] w,
                      input logic [31:0] p);
    bit is_branch, illegal, taken;
    int code, off;
    logic [31:0] exp_pc;
    string ttag, ptag;
    @(negedge clk);
    rst = r; cmp_valid = cv; cmp_a = a; cmp_b = b; br_valid = bv; br_insn = w; pc = p;
    #2;
    code = int'(w[13:10]);
    is_branch = bv && w[15] && w[14];
    illegal = is_branch && code >= 10;
    taken = 1'b0;
    if (is_branch && !illegal) begin
      if (code == 0) taken = m_eq;
      else if (code == 1) taken = !m_eq;
      else if (code == 2) taken = m_lt;
      else if (code == 3) taken = m_gt;
      else if (code == 4) taken = m_ltu;
      else if (code == 5) taken = m_gtu;
      else if (code == 6) taken = m_gt || m_eq;
      else if (code == 7) taken = m_lt || m_eq;
      else if (code == 8) taken = m_gtu || m_eq;
      else taken = m_ltu || m_eq;
    end
    off = int'(w[9:0]);
    if (off >= 512) off = off - 1024;
    if (illegal) exp_pc = p;
    else if (taken) exp_pc = p + 32'(off * 2);
    else exp_pc = p + 32'd2;
    if (!is_branch) ttag = "R4";
    else if (illegal) ttag = "R7";
    else if (code < 6) ttag = "R5";
    else ttag = "R6";
    if (!is_branch) ptag = "R4";
    else if (illegal) ptag = "R7";
    else if (taken) ptag = "R8";
    else ptag = "R9";
    check(ftag, 32'(cc_flags), 32'({m_gtu, m_ltu, m_gt, m_lt, m_eq}));
    check(ttag, 32'(br_taken), 32'(taken));
    check(ttag, 32'(br_illegal), 32'(illegal));
    check(ptag, next_pc, exp_pc);
    @(posedge clk);
    if (r) {m_eq, m_lt, m_gt, m_ltu, m_gtu} = '0;
    else if (cv) begin
      m_eq  = (a == b);
      m_lt  = ($signed(a) < $signed(b));
      m_gt  = ($signed(a) > $signed(b));
      m_ltu = (a < b);
      m_gtu = (a > b);
    end
  endtask

  function automatic logic [15:0] bw(input int code, input int off);
    return {2'b11, 4'(code), 10'(off)};
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    logic [15:0] w;
    repeat (2) @(posedge clk);
    // R1: flags zero after reset
    step("R1", 1, 0, 0, 0, 0, 0, 32'h100);
    step("R1", 0, 0, 0, 0, 1, bw(0, 4), 32'h100);
    // R2 and R5: equal compare, then branch on EQ
    step("R2", 0, 1, 32'h55, 32'h55, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1, bw(0, 8), 32'h200);
    step("R2", 0, 0, 0, 0, 1, bw(1, 8), 32'h200);
    // signed below, unsigned above
    step("R2", 0, 1, 32'hFFFF_FFF0, 32'h10, 0, 0, 0);
    for (int c = 0; c < 16; c++) step("R2", 0, 0, 0, 0, 1, bw(c, 3), 32'h400);
    // R3: compare and branch in the same cycle use the old flags
    step("R3", 0, 1, 32'h7, 32'h7, 1, bw(0, 5), 32'h500);
    step("R3", 0, 0, 0, 0, 1, bw(0, 5), 32'h500);
    // R4: word without both top bits is not a branch
    step("R3", 0, 0, 0, 0, 1, 16'h8000, 32'h600);
    step("R3", 0, 0, 0, 0, 1, 16'h4000, 32'h600);
    // R8: extreme displacements, R9: wrap on fall-through
    step("R3", 0, 0, 0, 0, 1, bw(0, 10'h200), 32'h1000);
    step("R3", 0, 0, 0, 0, 1, bw(0, 10'h1FF), 32'hFFFF_FF00);
    step("R3", 0, 0, 0, 0, 1, bw(1, 10'h1FF), 32'hFFFF_FFFE);
    // R7: illegal codes
    step("R3", 0, 0, 0, 0, 1, bw(10, 1), 32'h700);
    step("R3", 0, 0, 0, 0, 1, bw(15, 1), 32'h700);
    // R1: reset after live flags
    step("R2", 0, 1, 32'h1, 32'h2, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 1, bw(4, 2), 32'h40);
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      a = $urandom;
      case ($urandom % 4)
        0: b = a;
        1: b = a ^ 32'h8000_0000;
        2: b = a + 32'($urandom % 3) - 32'd1;
        default: b = $urandom;
      endcase
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15:14] = 2'b11;
      step("R2", 0, bit'($urandom % 2), a, b, bit'($urandom % 8 != 0), w,
           ($urandom % 8 == 0) ? 32'hFFFF_FFFE : {$urandom} & 32'hFFFF_FFFE);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule